// File: doc/BRIEF.md
# Dual Wiper Serial Control Interface

This block is the serial front end of a two-channel, 256-step digital potentiometer. A host reaches it over three wires: an active-high select, a serial clock and a data line. While the select is high, every rising serial clock moves one data bit into a 17-bit shift register. When the select drops, the register contents are copied into two 8-bit wiper codes and a stack-select flag. These outputs go to the tap decoders of the resistor arrays, which are not part of this block.

When the select rises, the shift register is preloaded with the present settings. The host can therefore read them back from the cascade output while it shifts new bits in. The bit that leaves the far end of the register is the cascade output. Several devices on one bus form one long chain: N devices need 17×N clocks per update.

The block runs on a fast system clock. It synchronizes all three serial inputs and detects their edges, so the serial clock must be much slower than the system clock.

Top module: `dpot_serial_ctrl`

## Requirements
- R1: After a synchronous reset, both wiper codes are 0x80, the stack-select flag is 0 and the cascade output enable is 0.
- R2: While the select input is low, serial clock edges and data changes leave the wiper codes, the flag and the shift register contents unchanged.
- R3: Frame bit 0, the first bit shifted in, becomes the stack-select flag.
- R4: Frame bits 1 to 8 become the wiper-1 code, with the MSB arriving first (bit 1) and the LSB last (bit 8).
- R5: Frame bits 9 to 16 become the wiper-0 code, MSB first (bit 9) and LSB last (bit 16).
- R6: The wiper codes and the flag change only when the select falls. During a transaction they keep their previous values. A transaction with no clocks leaves them unchanged.
- R7: On a rising select, the register is loaded with the present settings. Before each rising serial clock, the cascade output shows the next readback bit, in the same order as the frame layout of R3 to R5.
- R8: When more than 17 bits are sent, the last 17 bits are latched. Each bit shifted in appears on the cascade output 17 serial clocks later. A transaction shorter than 17 bits latches the remaining readback bits followed by the new bits.
- R9: The cascade output enable is high while the synchronized select is high and low while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_raw | input | 1 | Asynchronous active-high select |
| sclk_raw | input | 1 | Asynchronous serial clock |
| sdat_raw | input | 1 | Asynchronous serial data in |
| cas_out | output | 1 | Far-end bit of the shift register (readback and chain output) |
| cas_oe | output | 1 | Drive enable for the cascade and readback data |
| wiper0 | output | 8 | Wiper code of potentiometer 0 |
| wiper1 | output | 8 | Wiper code of potentiometer 1 |
| stack_sel | output | 1 | Stack-select flag |

## Verification
A corrupted shift register shows up at once on the cascade output, because every bit reaches it within 17 serial clocks. The bench therefore compares each cascade bit, before each serial clock, with a model of the old settings followed by the new data. A wrong capture, such as swapped fields or reversed bit order, shows on the wiper outputs a few system clocks after the select falls. A wiper that changes during a transaction, or a register that moves while the select is idle, is caught by the next wiper check or by the readback in the following transaction.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int WIPER_W = 8;
  localparam int FRAME_W = 2 * WIPER_W + 1;

  // Packed in shift-register order: the MSB leaves first.
  typedef struct packed {
    logic                 stack;
    logic [WIPER_W-1:0]   w1;
    logic [WIPER_W-1:0]   w0;
  } frame_t;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] sync,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], raw[b]};
        prev  <= chain[LAST];
      end
    end
    assign sync[b] = chain[LAST];
    assign rise[b] = chain[LAST] & ~prev;
    assign fall[b] = ~chain[LAST] & prev;
  end
endmodule

// File: rtl/dpot_shifter.sv
module dpot_shifter #(
  parameter int FW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] load_val,
  input  logic          shift,
  input  logic          din,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[FW-2:0], din};
  end
endmodule

// File: rtl/dpot_wipers.sv
module dpot_wipers #(
  parameter int WW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [2*WW:0]   frame,
  output logic [WW-1:0]   wiper0,
  output logic [WW-1:0]   wiper1,
  output logic            stack_sel
);
  localparam logic [WW-1:0] MID = WW'(1) << (WW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper0    <= MID;
      wiper1    <= MID;
      stack_sel <= 1'b0;
    end else if (capture) begin
      stack_sel <= frame[2*WW];
      wiper1    <= frame[2*WW-1:WW];
      wiper0    <= frame[WW-1:0];
    end
  end
endmodule

// File: rtl/dpot_serial_ctrl.sv
module dpot_serial_ctrl
  import dpot_pkg::*;
#(
  parameter int WW     = WIPER_W,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_raw,
  input  logic          sclk_raw,
  input  logic          sdat_raw,
  output logic          cas_out,
  output logic          cas_oe,
  output logic [WW-1:0] wiper0,
  output logic [WW-1:0] wiper1,
  output logic          stack_sel
);
  localparam int FW = 2 * WW + 1;
  localparam int IX_SEL = 0, IX_CLK = 1, IX_DAT = 2;

  logic [2:0]    s_lvl, s_rise, s_fall;
  logic          sel_s, ld, cap, shf;
  logic [FW-1:0] sreg;

  dpot_sync #(.W(3), .STAGES(STAGES)) u_sync (
    .clk (clk), .rst (rst),
    .raw ({sdat_raw, sclk_raw, sel_raw}),
    .sync(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign sel_s = s_lvl[IX_SEL];
  assign ld    = s_rise[IX_SEL];
  assign cap   = s_fall[IX_SEL];
  assign shf   = sel_s & ~ld & s_rise[IX_CLK];

  dpot_shifter #(.FW(FW)) u_shift (
    .clk (clk), .rst (rst),
    .load (ld), .load_val ({stack_sel, wiper1, wiper0}),
    .shift (shf), .din (s_lvl[IX_DAT]),
    .q (sreg)
  );

  dpot_wipers #(.WW(WW)) u_wip (
    .clk (clk), .rst (rst),
    .capture (cap), .frame (sreg),
    .wiper0 (wiper0), .wiper1 (wiper1), .stack_sel (stack_sel)
  );

  assign cas_out = sreg[FW-1];

  always_ff @(posedge clk) begin
    if (rst) cas_oe <= 1'b0;
    else     cas_oe <= sel_s;
  end
endmodule

// File: rtl/dpot_serial_chk.sv
module dpot_serial_chk #(
  parameter int WW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sel_s,
  input logic          ld,
  input logic          cap,
  input logic          shf,
  input logic [2*WW:0] sreg,
  input logic          cas_oe,
  input logic [WW-1:0] wiper0,
  input logic [WW-1:0] wiper1,
  input logic          stack_sel
);
  localparam logic [WW-1:0] MID = WW'(1) << (WW - 1);

  a_r1_reset_mid: assert property (@(posedge clk)
    rst |=> (wiper0 == MID && wiper1 == MID && !stack_sel && !cas_oe));

  a_r2_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    !sel_s |=> $stable(sreg));

  a_r6_hold_in_txn: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ($stable(wiper0) && $stable(wiper1) && $stable(stack_sel)));

  a_r7_load_readback: assert property (@(posedge clk) disable iff (rst)
    ld |=> sreg == {$past(stack_sel), $past(wiper1), $past(wiper0)});

  a_r9_release_on_capture: assert property (@(posedge clk) disable iff (rst)
    cap |=> !cas_oe);

  a_r6_single_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld, cap, shf}));
endmodule

bind dpot_serial_ctrl dpot_serial_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst(rst), .sel_s(sel_s), .ld(ld), .cap(cap), .shf(shf),
  .sreg(sreg), .cas_oe(cas_oe), .wiper0(wiper0), .wiper1(wiper1),
  .stack_sel(stack_sel)
);

// File: tb/sim_dpot_serial_ctrl.sv
module sim_dpot_serial_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst = 1;
  logic sel_raw = 0, sclk_raw = 0, sdat_raw = 0;
  logic cas_out, cas_oe, stack_sel;
  logic [7:0] wiper0, wiper1;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_w0 = 8'h80, m_w1 = 8'h80;
  logic m_st = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpot_serial_ctrl u0 (
    .clk(clk), .rst(rst), .sel_raw(sel_raw), .sclk_raw(sclk_raw),
    .sdat_raw(sdat_raw), .cas_out(cas_out), .cas_oe(cas_oe),
    .wiper0(wiper0), .wiper1(wiper1), .stack_sel(stack_sel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Readback bit i of the current settings (bit 0 stack, 1..8 w1 MSB first, 9..16 w0 MSB first).
  function automatic bit old_bit(input int i);
    if (i == 0) return m_st;
    if (i <= 8) return m_w1[8 - i];
    return m_w0[16 - i];
  endfunction

  task automatic check_wipers(input string tag);
    @(negedge clk);
    chk(stack_sel == m_st, {tag, " R3 stack"}, stack_sel, m_st);
    chk(wiper1 == m_w1, {tag, " R4 wiper1"}, wiper1, m_w1);
    chk(wiper0 == m_w0, {tag, " R5 wiper0"}, wiper0, m_w0);
  endtask

  task automatic txn(input int n, input bit [63:0] bits);
    bit sq [0:80];
    for (int i = 0; i < 17; i++) sq[i] = old_bit(i);
    for (int i = 0; i < n; i++) sq[17 + i] = bits[i];
    sel_raw = 1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(cas_oe == 1'b1, "R9 oe while selected", cas_oe, 1);
    for (int i = 0; i < n; i++) begin
      sdat_raw = bits[i];
      sclk_raw = 0;
      repeat (HALF) @(posedge clk);
      @(negedge clk);
      chk(cas_out == sq[i], (i < 17) ? "R7 readback bit" : "R8 pass-through bit",
          cas_out, sq[i]);
      sclk_raw = 1;
      repeat (HALF) @(posedge clk);
    end
    sclk_raw = 0;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    chk(wiper0 == m_w0 && wiper1 == m_w1 && stack_sel == m_st,
        "R6 hold during transaction", {stack_sel, wiper1, wiper0}, {m_st, m_w1, m_w0});
    sel_raw = 0;
    repeat (8) @(posedge clk);
    m_st = sq[n];
    for (int k = 0; k < 8; k++) m_w1[7 - k] = sq[n + 1 + k];
    for (int k = 0; k < 8; k++) m_w0[7 - k] = sq[n + 9 + k];
    check_wipers((n == 0) ? "R6 empty" : "R8 latch");
    chk(cas_oe == 1'b0, "R9 oe released", cas_oe, 0);
  endtask

  task automatic idle_noise(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      sdat_raw = $urandom_range(0, 1);
      sclk_raw = ~sclk_raw;
      repeat (HALF) @(posedge clk);
    end
    sclk_raw = 0;
    repeat (4) @(posedge clk);
    check_wipers("R2 idle");
  endtask

  function automatic bit [63:0] mk_frame(input bit st, input bit [7:0] w1, input bit [7:0] w0);
    bit [63:0] f = '0;
    f[0] = st;
    for (int k = 0; k < 8; k++) f[1 + k] = w1[7 - k];
    for (int k = 0; k < 8; k++) f[9 + k] = w0[7 - k];
    return f;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed));
    repeat (4) @(posedge clk);
    rst = 0;
    repeat (4) @(posedge clk);
    check_wipers("R1 reset");
    chk(cas_oe == 1'b0, "R1 oe after reset", cas_oe, 0);

    txn(17, mk_frame(1'b1, 8'hA5, 8'h3C));   // R3 R4 R5 directed
    txn(17, mk_frame(1'b0, 8'h01, 8'hFE));   // R7 readback of previous
    txn(0, '0);                              // R6 no clocks
    idle_noise(20);                          // R2
    txn(17, mk_frame(1'b1, 8'hFF, 8'h00));   // R7 confirms register untouched
    txn(34, {mk_frame(1'b0, 8'h12, 8'h34)[16:0], mk_frame(1'b1, 8'h80, 8'h7F)[16:0]}); // R8
    txn(5, 64'h15);                          // R8 short frame
    for (int t = 0; t < 30; t++) begin
      bit [63:0] b = {$urandom, $urandom};
      txn($urandom_range(0, 40), b);
      if (t % 5 == 0) idle_noise(8);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule